// File: doc/BRIEF.md
# Device Interrupt Pin Router

This block holds the per-device interrupt route settings for a small group of device numbers on a shared bus. It maps a device number and one of its four interrupt pins (INTA to INTD) to one of eight shared interrupt lines, numbered 0 to 7 for PIRQA to PIRQH. Software programs the routes through a 16-byte little-endian register window that takes byte, word and dword accesses. Interrupt logic elsewhere asks for routes through a separate combinational lookup port.

Devices 25 to 29 and 31 each have a programmable 16-bit route register. Device 30 is wired to a fixed route, and its register slot reads as zero. A device number outside 25 to 31 gets a default mapping that rotates with the slot number and only ever lands on the upper four lines. Every write access raises a one-cycle routing-changed pulse, so that consumers know to fetch their routes again.

Top module: `pin_route_top`

## Requirements
- R1: The route register for device d (25 to 29, or 31) sits at window byte offset 2*(d-25). Pin p (0=INTA to 3=INTD) owns bits [4p+3:4p]. The low three bits of that field are the line index returned by the lookup. The top bit of the field is stored and reads back as written.
- R2: Offsets 10 and 11 (device 30) always read zero, and writes to them are ignored. Looking up device 30 with pin p returns 4+p.
- R3: For a slot outside 25 to 31, looking up pin p returns ((slot+p) mod 4)+4.
- R4: bus_size 0 gives a 1-byte access, 1 gives 2 bytes, and 2 or 3 give 4 bytes. Byte k of bus_wdata and bus_rdata corresponds to window offset base+k (little-endian).
- R5: Only the low 4 address bits form the base, and the upper bits are ignored. Bytes of an access that fall past offset 15 are dropped on a write and read as zero.
- R6: Offsets 12 and 13 hold device 31. Offsets 14 and 15 read zero, and writes to them are ignored.
- R7: bus_rdata is registered. It takes the read result in the cycle after the read request and holds that value until the next read.
- R8: Every write request, whatever its offset, makes route_chg high for exactly the following cycle. With no write request, route_chg is low in the following cycle.
- R9: look_pirq is combinational from the stored routes, so a route written in one cycle is visible on the lookup port in the next cycle.
- R10: Synchronous reset loads 16'h3210 into every programmable register (INTA to line 0 through INTD to line 3), clears bus_rdata and holds route_chg low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address; the low 4 bits are used |
| bus_size | input | 2 | Access length code |
| bus_wdata | input | 32 | Write data, little-endian |
| bus_rdata | output | 32 | Registered read data |
| route_chg | output | 1 | One-cycle routing-changed pulse |
| look_slot | input | 5 | Device number to look up |
| look_pin | input | 2 | Interrupt pin, 0=INTA to 3=INTD |
| look_pirq | output | 3 | Shared line index, 0=PIRQA to 7=PIRQH |

## Verification
A corrupted route byte shows up on look_pirq in the very next cycle, but only for the slot and pin that use that field. For that reason the lookup inputs are swept over all 128 slot and pin pairs after each group of writes. A wrong byte enable or a wrong lane alignment first shows up when that byte is read back, one cycle after the read request. It can also show up as a changed neighbouring route on the lookup. A wrong notification state appears on route_chg in the cycle after the access.

// File: rtl/pir_pkg.sv
package pir_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;

  function automatic logic [2:0] bytes_of(input logic [1:0] sz);
    case (sz)
      2'd0:    bytes_of = 3'd1;
      2'd1:    bytes_of = 3'd2;
      default: bytes_of = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/pir_regs.sv
module pir_regs #(
  parameter int ADDR_W   = 12,
  parameter int WIN_LOG2 = 4,
  parameter int NUM_DEV  = 7,
  parameter int HARD_IDX = 5,
  parameter int REG_W    = 16,
  parameter logic [REG_W-1:0] DEF_ROUTE = 16'h3210
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [1:0]               size,
  input  logic [31:0]              wdata,
  output logic [31:0]              rdata,
  output logic                     chg,
  output logic [NUM_DEV*REG_W-1:0] route_flat
);
  import pir_pkg::*;

  localparam int WIN       = 1 << WIN_LOG2;
  localparam int REG_BYTES = REG_W / BYTE_W;
  localparam int USED      = NUM_DEV * REG_BYTES;
  localparam int OFF_W     = WIN_LOG2 + 1;

  logic [WIN_LOG2-1:0]        base;
  logic [ADDR_W-WIN_LOG2-1:0] addr_unused_hi;
  logic [2:0]                 nbytes;
  logic [OFF_W-1:0]           lane_off [LANES];
  logic [LANES-1:0]           lane_on;
  logic [BYTE_W-1:0]          img [WIN];
  logic [31:0]                rd_next;

  assign {addr_unused_hi, base} = addr;
  assign nbytes = bytes_of(size);

  // Each byte lane of an access targets base+k; lanes past the window end are dropped.
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_off[k] = {1'b0, base} + OFF_W'(k);
    assign lane_on[k]  = (3'(k) < nbytes) && !lane_off[k][WIN_LOG2];
  end

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    if (d == HARD_IDX) begin : g_hard
      assign route_flat[d*REG_W +: REG_W] = '0;
    end else begin : g_prog
      for (genvar j = 0; j < REG_BYTES; j++) begin : g_byte
        localparam int OFS = d * REG_BYTES + j;
        logic              hit;
        logic [BYTE_W-1:0] nxt;
        logic [BYTE_W-1:0] q;

        always_comb begin
          hit = 1'b0;
          nxt = q;
          for (int k = 0; k < LANES; k++) begin
            if (lane_on[k] && lane_off[k] == OFF_W'(OFS)) begin
              hit = 1'b1;
              nxt = wdata[BYTE_W*k +: BYTE_W];
            end
          end
        end

        always_ff @(posedge clk) begin
          if (rst)                q <= DEF_ROUTE[BYTE_W*j +: BYTE_W];
          else if (req && we && hit) q <= nxt;
        end

        assign route_flat[OFS*BYTE_W +: BYTE_W] = q;
      end
    end
  end

  for (genvar b = 0; b < WIN; b++) begin : g_img
    if (b < USED) begin : g_real
      assign img[b] = route_flat[b*BYTE_W +: BYTE_W];
    end else begin : g_hole
      assign img[b] = '0;
    end
  end

  always_comb begin
    rd_next = '0;
    for (int k = 0; k < LANES; k++) begin
      if (lane_on[k]) rd_next[BYTE_W*k +: BYTE_W] = img[lane_off[k][WIN_LOG2-1:0]];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      chg   <= 1'b0;
    end else begin
      chg <= req && we;
      if (req && !we) rdata <= rd_next;
    end
  end
endmodule

// File: rtl/pir_lookup.sv
module pir_lookup #(
  parameter int SLOT_W    = 5,
  parameter int PIN_W     = 2,
  parameter int PIRQ_W    = 3,
  parameter int FIELD_W   = 4,
  parameter int FIRST_DEV = 25,
  parameter int NUM_DEV   = 7,
  parameter int HARD_IDX  = 5,
  parameter int REG_W     = 16
) (
  input  logic [NUM_DEV*REG_W-1:0] route_flat,
  input  logic [SLOT_W-1:0]        slot,
  input  logic [PIN_W-1:0]         pin,
  output logic [PIRQ_W-1:0]        pirq
);
  localparam int IDX_W     = $clog2(NUM_DEV);
  localparam int HIGH_BASE = 1 << (PIRQ_W - 1);
  localparam int PINS      = 1 << PIN_W;

  logic [REG_W-1:0]  regs [NUM_DEV];
  logic [SLOT_W-1:0] rel;
  logic [IDX_W-1:0]  idx;
  logic              in_bank;
  logic [REG_W-1:0]  cur;

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_unpack
    assign regs[d] = route_flat[d*REG_W +: REG_W];
  end

  assign rel     = slot - SLOT_W'(FIRST_DEV);
  assign in_bank = rel < SLOT_W'(NUM_DEV);
  assign idx     = rel[IDX_W-1:0];

  always_comb begin
    cur = regs[idx];
    if (in_bank && rel != SLOT_W'(HARD_IDX))
      pirq = PIRQ_W'(cur >> (FIELD_W * pin));
    else if (in_bank)
      pirq = PIRQ_W'(HIGH_BASE + int'(pin));
    else
      pirq = PIRQ_W'(HIGH_BASE + ((int'(slot) + int'(pin)) % PINS));
  end
endmodule

// File: rtl/pin_route_top.sv
module pin_route_top #(
  parameter int ADDR_W    = 12,
  parameter int WIN_LOG2  = 4,
  parameter int SLOT_W    = 5,
  parameter int PIN_W     = 2,
  parameter int PIRQ_W    = 3,
  parameter int FIELD_W   = 4,
  parameter int FIRST_DEV = 25,
  parameter int NUM_DEV   = 7,
  parameter int HARD_DEV  = 30,
  parameter int REG_W     = 16,
  parameter logic [REG_W-1:0] DEF_ROUTE = 16'h3210
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              route_chg,
  input  logic [SLOT_W-1:0] look_slot,
  input  logic [PIN_W-1:0]  look_pin,
  output logic [PIRQ_W-1:0] look_pirq
);
  localparam int HARD_IDX = HARD_DEV - FIRST_DEV;

  logic [NUM_DEV*REG_W-1:0] route_flat;

  pir_regs #(
    .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .NUM_DEV(NUM_DEV),
    .HARD_IDX(HARD_IDX), .REG_W(REG_W), .DEF_ROUTE(DEF_ROUTE)
  ) u_regs (
    .clk(clk), .rst(rst), .req(bus_req), .we(bus_we), .addr(bus_addr),
    .size(bus_size), .wdata(bus_wdata), .rdata(bus_rdata), .chg(route_chg),
    .route_flat(route_flat)
  );

  pir_lookup #(
    .SLOT_W(SLOT_W), .PIN_W(PIN_W), .PIRQ_W(PIRQ_W), .FIELD_W(FIELD_W),
    .FIRST_DEV(FIRST_DEV), .NUM_DEV(NUM_DEV), .HARD_IDX(HARD_IDX), .REG_W(REG_W)
  ) u_look (
    .route_flat(route_flat), .slot(look_slot), .pin(look_pin), .pirq(look_pirq)
  );
endmodule

// File: rtl/pir_chk.sv
module pir_chk #(
  parameter int ADDR_W    = 12,
  parameter int WIN_LOG2  = 4,
  parameter int SLOT_W    = 5,
  parameter int PIN_W     = 2,
  parameter int PIRQ_W    = 3,
  parameter int FIRST_DEV = 25,
  parameter int NUM_DEV   = 7,
  parameter int HARD_DEV  = 30
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_size,
  input logic [31:0]       bus_rdata,
  input logic              route_chg,
  input logic [SLOT_W-1:0] look_slot,
  input logic [PIN_W-1:0]  look_pin,
  input logic [PIRQ_W-1:0] look_pirq
);
  localparam int HARD_OFS = 2 * (HARD_DEV - FIRST_DEV);

  a_r8_pulse_after_write: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_we) |=> route_chg);

  a_r8_quiet_without_write: assert property (@(posedge clk) disable iff (rst)
    !(bus_req && bus_we) |=> !route_chg);

  a_r2_fixed_slot_route: assert property (@(posedge clk) disable iff (rst)
    (int'(look_slot) == HARD_DEV) |-> (int'(look_pirq) == 4 + int'(look_pin)));

  a_r2_fixed_slot_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we && int'(bus_addr[WIN_LOG2-1:0]) == HARD_OFS && bus_size == 2'd0)
      |=> (bus_rdata[7:0] == 8'h00));

  a_r3_default_upper_lines: assert property (@(posedge clk) disable iff (rst)
    (int'(look_slot) < FIRST_DEV || int'(look_slot) >= FIRST_DEV + NUM_DEV)
      |-> look_pirq[PIRQ_W-1]);

  a_r9_no_write_no_change: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bus_req && bus_we) && $stable(look_slot) && $stable(look_pin))
      |-> $stable(look_pirq));

  a_r7_rdata_held: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bus_req && !bus_we)) |-> $stable(bus_rdata));

  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (bus_rdata == 32'h0 && !route_chg));
endmodule

bind pin_route_top pir_chk #(
  .ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2), .SLOT_W(SLOT_W), .PIN_W(PIN_W),
  .PIRQ_W(PIRQ_W), .FIRST_DEV(FIRST_DEV), .NUM_DEV(NUM_DEV), .HARD_DEV(HARD_DEV)
) u_chk (.*);

// File: tb/sim_pin_route_top.sv
`timescale 1ns/1ps
module sim_pin_route_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        chg;
  logic [4:0]  lslot = 5'd25;
  logic [1:0]  lpin = '0;
  logic [2:0]  pirq;

  int    checks = 0;
  int    failures = 0;
  bit    done = 0;
  string phase = "R10 reset state";

  // Behavioural reference state
  byte unsigned m_mem [16];
  logic [31:0]  m_rd = '0;
  logic         m_chg = 1'b0;

  always #2 clk = ~clk;

  pin_route_top u0 (
    .clk(clk), .rst(rst), .bus_req(req), .bus_we(we), .bus_addr(addr),
    .bus_size(size), .bus_wdata(wdata), .bus_rdata(rdata), .route_chg(chg),
    .look_slot(lslot), .look_pin(lpin), .look_pirq(pirq)
  );

  function automatic int exp_pirq(input int s, input int p);
    int b;
    if (s == 30) return 4 + p;
    if (s >= 25 && s <= 31) begin
      b = m_mem[2 * (s - 25) + p / 2];
      return (b >> (4 * (p % 2))) & 7;
    end
    return ((s + p) % 4) + 4;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < 16; b++) m_mem[b] = 8'h00;
      for (int d = 0; d < 7; d++) begin
        if (d != 5) begin
          m_mem[2*d]   = 8'h10;
          m_mem[2*d+1] = 8'h32;
        end
      end
      m_rd  = '0;
      m_chg = 1'b0;
    end else begin
      m_chg = req && we;
      if (req) begin
        int a;
        int n;
        logic [31:0] rv;
        a  = int'(addr) % 16;
        n  = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : 4;
        rv = '0;
        for (int k = 0; k < n; k++) begin
          int o;
          o = a + k;
          if (o < 16) begin
            if (we) begin
              if (o < 14 && o != 10 && o != 11) m_mem[o] = wdata[8*k +: 8];
            end else begin
              rv[8*k +: 8] = m_mem[o];
            end
          end
        end
        if (!we) m_rd = rv;
      end
    end
  end

  always begin
    @(posedge clk);
    #1;
    checks++;
    if (rdata !== m_rd) begin
      failures++;
      $display("FAIL %s: rdata act=%h exp=%h", phase, rdata, m_rd);
    end
    checks++;
    if (chg !== m_chg) begin
      failures++;
      $display("FAIL %s (R8): route_chg act=%b exp=%b", phase, chg, m_chg);
    end
    checks++;
    if (int'(pirq) != exp_pirq(int'(lslot), int'(lpin))) begin
      failures++;
      $display("FAIL %s (R9): slot %0d pin %0d pirq act=%0d exp=%0d",
               phase, lslot, lpin, pirq, exp_pirq(int'(lslot), int'(lpin)));
    end
  end

  task automatic acc(input logic w, input int a, input int sz, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a[11:0]; size = sz[1:0]; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic sweep();
    for (int s = 0; s < 32; s++) begin
      for (int p = 0; p < 4; p++) begin
        @(negedge clk);
        lslot = s[4:0]; lpin = p[1:0];
      end
    end
    @(negedge clk);
    lslot = 5'd25; lpin = 2'd0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: defaults visible at reads and lookup
    for (int o = 0; o < 16; o += 2) acc(1'b0, o, 1, 0);
    sweep();

    phase = "R1 per-device route";
    acc(1'b1, 0, 1, 32'h0000_7654);
    acc(1'b1, 2, 1, 32'h0000_1357);
    acc(1'b1, 4, 1, 32'h0000_F9AB);  // R1 top bit of field kept
    acc(1'b1, 6, 1, 32'h0000_0246);
    acc(1'b1, 8, 1, 32'h0000_8421);
    acc(1'b1, 12, 1, 32'h0000_C5E3);
    for (int o = 0; o < 16; o += 2) acc(1'b0, o, 1, 0);
    sweep();

    phase = "R4 little-endian sizes";
    acc(1'b1, 1, 0, 32'hFFFF_FFA5);
    acc(1'b1, 0, 2, 32'h4433_2211);
    acc(1'b0, 0, 2, 0);
    acc(1'b0, 1, 1, 0);
    acc(1'b1, 4, 3, 32'h8877_6655);
    acc(1'b0, 4, 3, 0);
    acc(1'b0, 5, 0, 0);

    phase = "R5 mask and clip";
    acc(1'b1, 12'h7F6, 1, 32'h0000_BEEF);
    acc(1'b0, 6, 1, 0);
    acc(1'b1, 13, 2, 32'hDDCC_BB9A);
    acc(1'b0, 12, 2, 0);
    acc(1'b0, 12'hABF, 2, 0);

    phase = "R2 fixed device";
    acc(1'b1, 10, 2, 32'h7766_5544);
    acc(1'b0, 10, 0, 0);
    acc(1'b0, 8, 2, 0);
    acc(1'b0, 10, 2, 0);

    phase = "R6 unused offsets";
    acc(1'b1, 14, 1, 32'h0000_FFFF);
    acc(1'b0, 14, 1, 0);
    acc(1'b0, 13, 2, 0);

    phase = "R7 R8 R9 timing";
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 12'd2; size = 2'd0; wdata = 32'h0000_0006;
    lslot = 5'd26; lpin = 2'd0;
    @(negedge clk);
    addr = 12'd3; wdata = 32'h0000_0071;
    lpin = 2'd2;
    @(negedge clk);
    we = 1'b0; addr = 12'd2; size = 2'd1;
    @(negedge clk);
    req = 1'b0;
    repeat (3) @(negedge clk);

    phase = "R3 R9 final sweep";
    sweep();

    phase = "R10 reset again";
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    acc(1'b0, 0, 2, 0);
    acc(1'b0, 8, 2, 0);
    sweep();

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule